// File: doc/BRIEF.md
# Ping-Pong Scratchpad Bank Controller

This block owns two identical banks of on-chip scratchpad storage. Each bank holds three separate stores: vertex data, edge data and the instruction stream of one subgraph. A DMA agent fills one bank while a graph processor computes on the other, so data movement overlaps with computation. The processor never starts on its own. The DMA agent loads a bank and raises a start. The controller hands that bank to the processor as soon as the processor is free. When the processor reports completion, the bank goes back to the DMA side. The DMA agent then copies the updated results out and may load the bank again.

Each side has one access port: a store select, an address, write data and a write enable. The controller routes each port to the bank that the side currently owns and blocks accesses that the ownership rules do not permit. A saturating counter records how many cycles the processor sits idle with no loaded bank ready. This measures compute stalls caused by data loading.

Bank state encoding used below: empty (DMA may read and write), full (loaded, waiting for the processor), busy (owned by the processor), drained (results held for DMA read-back). Store select encoding on both ports: 0 = vertex store, 1 = edge store, 2 = instruction store, 3 = no store (reads return zero, writes are dropped).

Top module: `dbuf_scratch_ctrl`

## Requirements
- R1: After a synchronous active-high reset, both banks are empty, `dma_bank` is 0, `proc_idle` is 1, `proc_go` is 0, `dma_can_write` and `dma_can_read` are 1, and `stall_cycles` is 0.
- R2: A `dma_start` pulse is accepted only when the bank addressed by `dma_bank` is empty. Acceptance marks that bank full and toggles `dma_bank`. Otherwise the start has no effect and `dma_bank` holds. `dma_bank` changes only on an accepted start.
- R3: When no bank is busy and the next bank in launch order is full, that bank becomes busy at the next clock edge. At the same time `proc_go` is high for exactly one cycle, `proc_bank` names the bank and `proc_idle` falls. Banks launch in the order in which they were started.
- R4: A start accepted while the processor is busy is held pending. The waiting bank launches on the clock edge after the one that retires the busy bank.
- R5: A `proc_done` pulse while a bank is busy moves that bank to drained and raises `proc_idle` after the edge. Results the processor wrote are then readable from the DMA port. A `proc_done` while idle has no effect.
- R6: `dma_wb_done` moves the drained bank addressed by `dma_bank` back to empty, which re-enables DMA writes. On an empty bank it has no effect.
- R7: DMA writes land only in an empty bank. A drained bank is readable but not writable from the DMA port. Processor writes land only while the processor owns a busy bank. Writes that are not permitted leave the stored data unchanged.
- R8: The three stores of a bank and the two banks hold independent data. The same address in different stores, or in different banks, returns its own value. Read data appears one cycle after the address is presented.
- R9: `stall_cycles` increases by one on every clock edge at which no bank is busy and the next bank in launch order is not full. It saturates at its all-ones value.
- R10: `stall_cycles` holds while the processor is busy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dma_start | input | 1 | Pulse: bank at `dma_bank` is loaded, start it |
| dma_wb_done | input | 1 | Pulse: read-back of drained bank at `dma_bank` complete |
| dma_sel | input | 2 | DMA store select (0 vertex, 1 edge, 2 instruction, 3 none) |
| dma_addr | input | ADDR_W | DMA word address |
| dma_we | input | 1 | DMA write enable |
| dma_wdata | input | DATA_W | DMA write data |
| dma_rdata | output | DATA_W | DMA read data, one cycle after address |
| dma_bank | output | 1 | Bank the DMA side currently addresses |
| dma_can_write | output | 1 | DMA bank is empty and writable |
| dma_can_read | output | 1 | DMA bank is empty or drained and readable |
| proc_go | output | 1 | One-cycle pulse: a bank was handed to the processor |
| proc_done | input | 1 | Pulse from processor: subgraph finished |
| proc_idle | output | 1 | No bank is busy |
| proc_bank | output | 1 | Bank owned by the processor |
| proc_sel | input | 2 | Processor store select |
| proc_addr | input | ADDR_W | Processor word address |
| proc_we | input | 1 | Processor write enable |
| proc_wdata | input | DATA_W | Processor write data |
| proc_rdata | output | DATA_W | Processor read data, one cycle after address |
| stall_cycles | output | STALL_W | Saturating count of idle cycles waiting for data |

## Verification
The bank swap is exercised with three timing patterns. In the first, a start arrives with the processor idle, so the launch is immediate. In the second, a start arrives while the processor is busy and the launch must wait for completion. In the third, a second start is refused because its bank is still owned by the processor. Together these separate immediate launch, pending launch and start rejection. A fixed set of store, address and data vectors is written into each bank and read back through both ports. Distinct data per bank, plus entries that share an address across stores, shows whether stores and banks alias. Writes attempted from the wrong side or in the wrong state are followed by read-back of the same location. The stall counter is sampled while idle, while busy and after a long idle stretch, which separates counting, freezing and saturation.

// File: rtl/dbuf_pkg.sv
package dbuf_pkg;

    typedef enum logic [1:0] {
        BK_EMPTY = 2'd0,
        BK_FULL  = 2'd1,
        BK_BUSY  = 2'd2,
        BK_DRAIN = 2'd3
    } bank_st_e;

    typedef enum logic [1:0] {
        SP_VTX   = 2'd0,
        SP_EDGE  = 2'd1,
        SP_INSTR = 2'd2,
        SP_NONE  = 2'd3
    } store_e;

    function automatic int max3(int a, int b, int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic logic dma_may_read(bank_st_e s);
        return (s == BK_EMPTY) || (s == BK_DRAIN);
    endfunction

endpackage

// File: rtl/dbuf_bank.sv
module dbuf_bank #(
    parameter int DW = 32,
    parameter int VD = 64,
    parameter int ED = 256,
    parameter int ID = 64,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic          we,
    input  logic [1:0]    sel,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic       en_q;
    logic [1:0] sel_q;

    for (genvar s = 0; s < 3; s++) begin : g_store
        localparam int D  = (s == 0) ? VD : ((s == 1) ? ED : ID);
        localparam int LW = $clog2(D);
        logic [DW-1:0] mem [D];
        logic [DW-1:0] rd;
        always_ff @(posedge clk) begin
            if (en && we && (sel == 2'(s))) begin
                mem[addr[LW-1:0]] <= wdata;
            end
            rd <= mem[addr[LW-1:0]];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q  <= 1'b0;
            sel_q <= 2'd3;
        end else begin
            en_q  <= en;
            sel_q <= sel;
        end
    end

    always_comb begin
        rdata = '0;
        if (en_q) begin
            case (sel_q)
                2'd0:    rdata = g_store[0].rd;
                2'd1:    rdata = g_store[1].rd;
                2'd2:    rdata = g_store[2].rd;
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/dbuf_pingpong_ctrl.sv
module dbuf_pingpong_ctrl
    import dbuf_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               dma_start,
    input  logic               dma_wb_done,
    input  logic               proc_done,
    output bank_st_e [1:0]     st_o,
    output logic               dma_ptr_o,
    output logic               run_ptr_o,
    output logic               go_o,
    output logic               busy_o,
    output logic               waiting_o
);
    bank_st_e [1:0] st_q;
    logic dma_ptr, nxt_ptr, run_ptr, go_q;
    logic busy, launch, finish;

    always_comb begin
        busy   = (st_q[0] == BK_BUSY) || (st_q[1] == BK_BUSY);
        launch = !busy && (st_q[nxt_ptr] == BK_FULL);
        finish = proc_done && busy;
    end

    // Each event targets a bank in a distinct state, so no two touch the same bank.
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q[0] <= BK_EMPTY;
            st_q[1] <= BK_EMPTY;
            dma_ptr <= 1'b0;
            nxt_ptr <= 1'b0;
            run_ptr <= 1'b0;
            go_q    <= 1'b0;
        end else begin
            go_q <= launch;
            if (dma_start && (st_q[dma_ptr] == BK_EMPTY)) begin
                st_q[dma_ptr] <= BK_FULL;
                dma_ptr       <= ~dma_ptr;
            end
            if (dma_wb_done && (st_q[dma_ptr] == BK_DRAIN)) begin
                st_q[dma_ptr] <= BK_EMPTY;
            end
            if (launch) begin
                st_q[nxt_ptr] <= BK_BUSY;
                run_ptr       <= nxt_ptr;
                nxt_ptr       <= ~nxt_ptr;
            end
            if (finish) begin
                st_q[run_ptr] <= BK_DRAIN;
            end
        end
    end

    assign st_o      = st_q;
    assign dma_ptr_o = dma_ptr;
    assign run_ptr_o = run_ptr;
    assign go_o      = go_q;
    assign busy_o    = busy;
    assign waiting_o = !busy && !launch;
endmodule

// File: rtl/dbuf_stall_meter.sv
module dbuf_stall_meter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wait_i,
    output logic [W-1:0] count_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            count_o <= '0;
        end else if (wait_i && (count_o != '1)) begin
            count_o <= count_o + 1'b1;
        end
    end
endmodule

// File: rtl/dbuf_scratch_ctrl.sv
module dbuf_scratch_ctrl
    import dbuf_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int VTX_DEPTH   = 64,
    parameter int EDGE_DEPTH  = 256,
    parameter int INSTR_DEPTH = 64,
    parameter int STALL_W     = 16,
    localparam int ADDR_W     = $clog2(max3(VTX_DEPTH, EDGE_DEPTH, INSTR_DEPTH))
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               dma_start,
    input  logic               dma_wb_done,
    input  logic [1:0]         dma_sel,
    input  logic [ADDR_W-1:0]  dma_addr,
    input  logic               dma_we,
    input  logic [DATA_W-1:0]  dma_wdata,
    output logic [DATA_W-1:0]  dma_rdata,
    output logic               dma_bank,
    output logic               dma_can_write,
    output logic               dma_can_read,
    output logic               proc_go,
    input  logic               proc_done,
    output logic               proc_idle,
    output logic               proc_bank,
    input  logic [1:0]         proc_sel,
    input  logic [ADDR_W-1:0]  proc_addr,
    input  logic               proc_we,
    input  logic [DATA_W-1:0]  proc_wdata,
    output logic [DATA_W-1:0]  proc_rdata,
    output logic [STALL_W-1:0] stall_cycles
);
    bank_st_e [1:0] st;
    logic dma_ptr, run_ptr, busy, waiting;
    logic [1:0][DATA_W-1:0] bank_rd;
    logic proc_ok_q, proc_bsel_q, dma_ok_q, dma_bsel_q;

    dbuf_pingpong_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .dma_start  (dma_start),
        .dma_wb_done(dma_wb_done),
        .proc_done  (proc_done),
        .st_o       (st),
        .dma_ptr_o  (dma_ptr),
        .run_ptr_o  (run_ptr),
        .go_o       (proc_go),
        .busy_o     (busy),
        .waiting_o  (waiting)
    );

    dbuf_stall_meter #(.W(STALL_W)) u_stall (
        .clk    (clk),
        .rst    (rst),
        .wait_i (waiting),
        .count_o(stall_cycles)
    );

    for (genvar b = 0; b < 2; b++) begin : g_bank
        logic proc_own, dma_own, en, we;
        logic [1:0]        sel;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;

        always_comb begin
            proc_own = (st[b] == BK_BUSY);
            dma_own  = (dma_ptr == 1'(b)) && dma_may_read(st[b]);
            en       = proc_own || dma_own;
            we       = proc_own ? proc_we : (dma_own && dma_we && (st[b] == BK_EMPTY));
            sel      = proc_own ? proc_sel   : dma_sel;
            addr     = proc_own ? proc_addr  : dma_addr;
            wdata    = proc_own ? proc_wdata : dma_wdata;
        end

        dbuf_bank #(
            .DW(DATA_W), .VD(VTX_DEPTH), .ED(EDGE_DEPTH), .ID(INSTR_DEPTH), .AW(ADDR_W)
        ) u_bank (
            .clk  (clk),
            .rst  (rst),
            .en   (en),
            .we   (we),
            .sel  (sel),
            .addr (addr),
            .wdata(wdata),
            .rdata(bank_rd[b])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            proc_ok_q   <= 1'b0;
            proc_bsel_q <= 1'b0;
            dma_ok_q    <= 1'b0;
            dma_bsel_q  <= 1'b0;
        end else begin
            proc_ok_q   <= busy;
            proc_bsel_q <= run_ptr;
            dma_ok_q    <= dma_may_read(st[dma_ptr]);
            dma_bsel_q  <= dma_ptr;
        end
    end

    assign proc_rdata    = proc_ok_q ? bank_rd[proc_bsel_q] : '0;
    assign dma_rdata     = dma_ok_q  ? bank_rd[dma_bsel_q]  : '0;
    assign dma_bank      = dma_ptr;
    assign dma_can_write = (st[dma_ptr] == BK_EMPTY);
    assign dma_can_read  = dma_may_read(st[dma_ptr]);
    assign proc_idle     = !busy;
    assign proc_bank     = run_ptr;
endmodule

// File: rtl/dbuf_scratch_ctrl_chk.sv
module dbuf_scratch_ctrl_chk #(
    parameter int STALL_W = 16
) (
    input logic               clk,
    input logic               rst,
    input logic               dma_start,
    input logic               dma_can_write,
    input logic               dma_bank,
    input logic               proc_go,
    input logic               proc_done,
    input logic               proc_idle,
    input logic               proc_bank,
    input logic [STALL_W-1:0] stall_cycles
);
    a_r3_go_single: assert property (@(posedge clk) disable iff (rst)
        proc_go |=> !proc_go);

    a_r3_go_busy: assert property (@(posedge clk) disable iff (rst)
        proc_go |-> !proc_idle);

    a_r5_done_frees: assert property (@(posedge clk) disable iff (rst)
        (proc_done && !proc_idle) |=> proc_idle);

    a_r2_start_moves: assert property (@(posedge clk) disable iff (rst)
        (dma_start && dma_can_write) |=> (dma_bank != $past(dma_bank)));

    a_r2_start_needed: assert property (@(posedge clk) disable iff (rst)
        !dma_start |=> (dma_bank == $past(dma_bank)));

    a_r7_busy_locked: assert property (@(posedge clk) disable iff (rst)
        proc_go |-> !(dma_can_write && (dma_bank == proc_bank)));

    a_r10_frozen: assert property (@(posedge clk) disable iff (rst)
        !proc_idle |=> (stall_cycles == $past(stall_cycles)));

    a_r9_step: assert property (@(posedge clk) disable iff (rst)
        proc_idle |=> ((stall_cycles == $past(stall_cycles)) ||
                       (stall_cycles == $past(stall_cycles) + 1'b1)));
endmodule

bind dbuf_scratch_ctrl dbuf_scratch_ctrl_chk #(.STALL_W(STALL_W)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .dma_start    (dma_start),
    .dma_can_write(dma_can_write),
    .dma_bank     (dma_bank),
    .proc_go      (proc_go),
    .proc_done    (proc_done),
    .proc_idle    (proc_idle),
    .proc_bank    (proc_bank),
    .stall_cycles (stall_cycles)
);

// File: tb/dbuf_scratch_ctrl_test.sv
module dbuf_scratch_ctrl_test;
    localparam int CLK_P   = 10;
    localparam int STALL_W = 8;

    typedef struct packed {
        logic [1:0]  sel;
        logic [7:0]  addr;
        logic [31:0] data;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{2'd0, 8'd0,   32'h1111_0001},
        '{2'd1, 8'd0,   32'h2222_0002},
        '{2'd2, 8'd0,   32'h3333_0003},
        '{2'd0, 8'd63,  32'hA5A5_0004},
        '{2'd1, 8'd255, 32'h5A5A_0005},
        '{2'd1, 8'd5,   32'h0F0F_0006},
        '{2'd2, 8'd63,  32'hDEAD_0007},
        '{2'd0, 8'd17,  32'hBEEF_0008}
    };

    logic clk = 1'b0;
    logic rst;
    logic dma_start, dma_wb_done, dma_we, proc_done, proc_we;
    logic [1:0] dma_sel, proc_sel;
    logic [7:0] dma_addr, proc_addr;
    logic [31:0] dma_wdata, proc_wdata, dma_rdata, proc_rdata;
    logic dma_bank, dma_can_write, dma_can_read, proc_go, proc_idle, proc_bank;
    logic [STALL_W-1:0] stall_cycles;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;
    logic [STALL_W-1:0] snap;

    always #(CLK_P/2) clk = ~clk;

    dbuf_scratch_ctrl #(.STALL_W(STALL_W)) uut (
        .clk(clk), .rst(rst),
        .dma_start(dma_start), .dma_wb_done(dma_wb_done),
        .dma_sel(dma_sel), .dma_addr(dma_addr), .dma_we(dma_we),
        .dma_wdata(dma_wdata), .dma_rdata(dma_rdata),
        .dma_bank(dma_bank), .dma_can_write(dma_can_write), .dma_can_read(dma_can_read),
        .proc_go(proc_go), .proc_done(proc_done), .proc_idle(proc_idle),
        .proc_bank(proc_bank), .proc_sel(proc_sel), .proc_addr(proc_addr),
        .proc_we(proc_we), .proc_wdata(proc_wdata), .proc_rdata(proc_rdata),
        .stall_cycles(stall_cycles)
    );

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic dma_wr(logic [1:0] s, logic [7:0] a, logic [31:0] d);
        dma_we = 1'b1; dma_sel = s; dma_addr = a; dma_wdata = d;
        step();
        dma_we = 1'b0;
    endtask

    task automatic dma_rd_chk(string tag, logic [1:0] s, logic [7:0] a, logic [31:0] exp);
        dma_sel = s; dma_addr = a;
        step();
        chk(tag, dma_rdata, exp);
    endtask

    task automatic proc_rd_chk(string tag, logic [1:0] s, logic [7:0] a, logic [31:0] exp);
        proc_sel = s; proc_addr = a;
        step();
        chk(tag, proc_rdata, exp);
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1;
        dma_start = 0; dma_wb_done = 0; dma_we = 0; proc_done = 0; proc_we = 0;
        dma_sel = 0; proc_sel = 0; dma_addr = 0; proc_addr = 0;
        dma_wdata = 0; proc_wdata = 0;
        repeat (3) step();
        rst = 1'b0;

        // R1 reset state
        chk("R1 idle", 32'(proc_idle), 32'd1);
        chk("R1 go", 32'(proc_go), 32'd0);
        chk("R1 bank", 32'(dma_bank), 32'd0);
        chk("R1 can_write", 32'(dma_can_write), 32'd1);
        chk("R1 can_read", 32'(dma_can_read), 32'd1);
        chk("R1 stall", 32'(stall_cycles), 32'd0);

        // R9 counting while idle with nothing loaded
        repeat (5) step();
        chk("R9 stall count", 32'(stall_cycles), 32'd5);

        // R8 fill bank 0 from the vector table
        for (int i = 0; i < 8; i++) dma_wr(VECS[i].sel, VECS[i].addr, VECS[i].data);

        // R7 processor write while idle must not land
        proc_we = 1'b1; proc_sel = 2'd0; proc_addr = 8'd0; proc_wdata = 32'h0BAD_0BAD;
        step();
        proc_we = 1'b0;

        for (int i = 0; i < 8; i++)
            dma_rd_chk("R8 R7 bank0 readback", VECS[i].sel, VECS[i].addr, VECS[i].data);
        dma_rd_chk("R8 none store", 2'd3, 8'd0, 32'd0);

        // R2 start accepted, R3 launch
        dma_start = 1'b1; step(); dma_start = 1'b0;
        chk("R2 bank toggles", 32'(dma_bank), 32'd1);
        chk("R3 go not yet", 32'(proc_go), 32'd0);
        step();
        chk("R3 go pulse", 32'(proc_go), 32'd1);
        chk("R3 proc bank", 32'(proc_bank), 32'd0);
        chk("R3 idle low", 32'(proc_idle), 32'd0);
        snap = stall_cycles;
        step();
        chk("R3 go one cycle", 32'(proc_go), 32'd0);
        repeat (2) step();
        chk("R10 stall frozen", 32'(stall_cycles), 32'(snap));

        // R8 processor sees bank 0 contents
        for (int i = 0; i < 8; i++)
            proc_rd_chk("R8 proc bank0", VECS[i].sel, VECS[i].addr, VECS[i].data);
        proc_we = 1'b1; proc_sel = 2'd1; proc_addr = 8'd5; proc_wdata = 32'hCAFE_F00D;
        step();
        proc_we = 1'b0;

        // Prefetch bank 1 while bank 0 is busy
        chk("R7 bank1 writable", 32'(dma_can_write), 32'd1);
        for (int i = 0; i < 8; i++) dma_wr(VECS[i].sel, VECS[i].addr, VECS[i].data ^ 32'h0000_FFFF);
        dma_start = 1'b1; step(); dma_start = 1'b0;
        chk("R2 bank back to 0", 32'(dma_bank), 32'd0);
        chk("R7 busy bank locked", 32'(dma_can_write), 32'd0);
        dma_start = 1'b1; step(); dma_start = 1'b0;
        chk("R2 refused start", 32'(dma_bank), 32'd0);
        repeat (2) step();
        chk("R4 held pending", 32'(proc_go), 32'd0);

        // R5 done, R4 pending launch
        proc_done = 1'b1; step(); proc_done = 1'b0;
        chk("R5 idle after done", 32'(proc_idle), 32'd1);
        chk("R5 drained readable", 32'(dma_can_read), 32'd1);
        chk("R7 drained not writable", 32'(dma_can_write), 32'd0);
        step();
        chk("R4 launch after done", 32'(proc_go), 32'd1);
        chk("R4 proc bank 1", 32'(proc_bank), 32'd1);

        // R5 results visible, R7 drained write dropped
        dma_rd_chk("R5 result readback", 2'd1, 8'd5, 32'hCAFE_F00D);
        dma_wr(2'd0, 8'd0, 32'h0000_0000);
        dma_rd_chk("R7 drained write dropped", 2'd0, 8'd0, 32'h1111_0001);

        // R6 write-back done
        dma_wb_done = 1'b1; step(); dma_wb_done = 1'b0;
        chk("R6 empty again", 32'(dma_can_write), 32'd1);
        dma_wb_done = 1'b1; step(); dma_wb_done = 1'b0;
        chk("R6 no effect empty", 32'(dma_can_write), 32'd1);
        chk("R6 bank held", 32'(dma_bank), 32'd0);

        // R8 bank 1 independent of bank 0
        for (int i = 0; i < 8; i++)
            proc_rd_chk("R8 proc bank1", VECS[i].sel, VECS[i].addr, VECS[i].data ^ 32'h0000_FFFF);

        proc_done = 1'b1; step(); proc_done = 1'b0;
        chk("R5 idle bank1 done", 32'(proc_idle), 32'd1);
        proc_done = 1'b1; step(); proc_done = 1'b0;
        chk("R5 done while idle", 32'(proc_idle), 32'd1);
        chk("R5 no go", 32'(proc_go), 32'd0);

        // R9 counting and saturation
        snap = stall_cycles;
        repeat (4) step();
        chk("R9 counts idle", 32'(stall_cycles), 32'(snap) + 32'd4);
        repeat (300) step();
        chk("R9 saturates", 32'(stall_cycles), 32'd255);

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule